// File: doc/BRIEF.md
# Machine Check Bank Error Recorder

This block keeps the error-reporting state of a small set of machine-check banks and decides what happens to each error report that an injection port presents. Each bank holds a status word, an error address and a miscellaneous word. A global status register records whether a machine check is in progress. The capability word, the global control word, the per-bank control words and the machine-check enable are configuration inputs driven by the surrounding core.

An injection names a bank and carries a status word, a global status word, an address, a misc word and an unconditional flag. In one cycle the block rejects the injection, ignores it, drops it, turns it into a reset request, or records it. Recording an uncorrected error also raises a one-cycle machine-check interrupt. A result strobe with an action code follows every injection. A combinational read port returns the contents of any bank.

Top module: `mcb_recorder`

## Requirements
- R1: An injection is rejected (action code 3, no bank or global status change) when the capability word is zero, when the bank number is not below capability bits 7:0 or not below the number of banks built, or when status bit 63 (valid) is clear.
- R2: When global status bit 2 (in progress) is set and status bit 55 (action required) is clear, the injection is ignored (action code 0, no state change) unless the unconditional flag is set.
- R3: An uncorrected error (status bit 61) is dropped (action code 4, no state change) when capability bit 8 is set and the global control word is not all ones, or when the addressed bank's control word is not all ones.
- R4: An uncorrected error that is not dropped produces a one-cycle reset request (action code 2, no state change) when the machine-check enable is low or global status bit 2 is set.
- R5: Otherwise an uncorrected error is recorded (action code 1): the bank's status becomes the new status with bit 62 (overflow) set if the bank already held a valid status; address and misc are written; global status takes the injected global status; the machine-check interrupt pulses for one cycle.
- R6: A corrected error (bit 61 clear) that reaches the bank while it holds no valid status, or holds a corrected one, overwrites status, address and misc (action code 1); bit 62 is set only when the old status was valid.
- R7: A corrected error that reaches a bank holding a valid uncorrected status only sets bit 62 of the existing status; address and misc are kept (action code 1).
- R8: The result strobe, action code, interrupt and reset request appear in the cycle after the injection is sampled and last exactly one cycle; interrupt and reset request never pulse without the strobe.
- R9: After reset every bank status, address and misc word, the global status and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_i | input | 64 | Capability word: bits 7:0 bank count, bit 8 global control present |
| gctl_i | input | 64 | Global control word |
| bank_ctl_i | input | NBANK*64 | Per-bank control words, bank n at bits n*64 upward |
| mce_en_i | input | 1 | Machine-check enable from the core control register |
| inj_valid_i | input | 1 | Injection request, one per cycle |
| inj_bank_i | input | 8 | Target bank number |
| inj_status_i | input | 64 | Error status word |
| inj_gstat_i | input | 64 | Global status to load when an uncorrected error is recorded |
| inj_addr_i | input | 64 | Error address |
| inj_misc_i | input | 64 | Miscellaneous error word |
| inj_uncond_i | input | 1 | Bypass the in-progress ignore rule |
| rd_bank_i | input | 8 | Bank selected on the read port; out-of-range reads return zero |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_action_o | output | 3 | 0 ignored, 1 injected, 2 reset, 3 rejected, 4 dropped |
| mce_irq_o | output | 1 | One-cycle machine-check interrupt |
| reset_req_o | output | 1 | One-cycle reset request |
| gstat_o | output | 64 | Global status register |
| rd_status_o | output | 64 | Status of the selected bank |
| rd_addr_o | output | 64 | Address of the selected bank |
| rd_misc_o | output | 64 | Misc word of the selected bank |

## Verification
An injection sampled on one rising edge shows its strobe, action code, interrupt and reset request right after the next rising edge, and bank and global status take their new values at that same edge; the read port is combinational, so the new bank contents are visible in that cycle too. The bench reference model advances on each rising edge from the sampled inputs and its own state. All outputs are compared a quarter period after each edge, while the inputs change only on falling edges, so every comparison falls inside the cycle in which the result is due.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
   localparam int REG_W     = 64;
   localparam int ST_VAL    = 63;
   localparam int ST_OVER   = 62;
   localparam int ST_UC     = 61;
   localparam int ST_AR     = 55;
   localparam int GS_INPROG = 2;
   localparam int GS_RIPV   = 0;
   localparam int CAP_CTLP  = 8;
   localparam int CAP_CNT_W = 8;

   typedef enum logic [2:0] {
      ACT_IGNORED  = 3'd0,
      ACT_INJECTED = 3'd1,
      ACT_RESET    = 3'd2,
      ACT_REJECTED = 3'd3,
      ACT_DROPPED  = 3'd4
   } mcb_act_e;

   typedef enum logic [1:0] {
      WR_NONE = 2'd0,
      WR_FULL = 2'd1,
      WR_OVER = 2'd2
   } mcb_wr_e;
endpackage

// File: rtl/mcb_decide.sv
module mcb_decide
   import mcb_pkg::*;
#(
   parameter int NBANK = 4
) (
   input  logic [REG_W-1:0]     cap,
   input  logic [REG_W-1:0]     gctl,
   input  logic [REG_W-1:0]     bank_ctl,
   input  logic                 mce_en,
   input  logic [CAP_CNT_W-1:0] bank,
   input  logic [REG_W-1:0]     status,
   input  logic [REG_W-1:0]     gstat_cur,
   input  logic                 uncond,
   input  logic [REG_W-1:0]     old_status,
   output mcb_act_e             act,
   output mcb_wr_e              wr,
   output logic [REG_W-1:0]     new_status,
   output logic                 gstat_wr,
   output logic                 irq,
   output logic                 rst_req
);
   logic bad_bank, in_prog, old_v, old_uc;

   always_comb begin
      bad_bank = (bank >= cap[CAP_CNT_W-1:0]) || (32'(bank) >= NBANK);
      in_prog  = gstat_cur[GS_INPROG];
      old_v    = old_status[ST_VAL];
      old_uc   = old_status[ST_UC];
      act        = ACT_REJECTED;
      wr         = WR_NONE;
      new_status = status;
      gstat_wr   = 1'b0;
      irq        = 1'b0;
      rst_req    = 1'b0;
      if (cap == '0 || bad_bank || !status[ST_VAL]) begin
         act = ACT_REJECTED;
      end else if (!uncond && !status[ST_AR] && in_prog) begin
         act = ACT_IGNORED;
      end else if (status[ST_UC]) begin
         if ((cap[CAP_CTLP] && gctl != '1) || bank_ctl != '1) begin
            act = ACT_DROPPED;
         end else if (!mce_en || in_prog) begin
            act     = ACT_RESET;
            rst_req = 1'b1;
         end else begin
            act                 = ACT_INJECTED;
            wr                  = WR_FULL;
            new_status[ST_OVER] = status[ST_OVER] | old_v;
            gstat_wr            = 1'b1;
            irq                 = 1'b1;
         end
      end else if (!old_v || !old_uc) begin
         act                 = ACT_INJECTED;
         wr                  = WR_FULL;
         new_status[ST_OVER] = status[ST_OVER] | old_v;
      end else begin
         act = ACT_INJECTED;
         wr  = WR_OVER;
      end
   end
endmodule

// File: rtl/mcb_bank_store.sv
module mcb_bank_store
   import mcb_pkg::*;
#(
   parameter int NBANK = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CAP_CNT_W-1:0] wr_sel,
   input  mcb_wr_e              wr_kind,
   input  logic [REG_W-1:0]     wr_status,
   input  logic [REG_W-1:0]     wr_addr,
   input  logic [REG_W-1:0]     wr_misc,
   input  logic [CAP_CNT_W-1:0] a_sel,
   output logic [REG_W-1:0]     a_status,
   input  logic [CAP_CNT_W-1:0] b_sel,
   output logic [REG_W-1:0]     b_status,
   output logic [REG_W-1:0]     b_addr,
   output logic [REG_W-1:0]     b_misc
);
   logic [REG_W-1:0] st_arr [NBANK];
   logic [REG_W-1:0] ad_arr [NBANK];
   logic [REG_W-1:0] mi_arr [NBANK];

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      logic [REG_W-1:0] st_q, ad_q, mi_q;
      logic             hit;
      assign hit = (wr_sel == CAP_CNT_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q <= '0;
            ad_q <= '0;
            mi_q <= '0;
         end else if (hit && wr_kind == WR_FULL) begin
            st_q <= wr_status;
            ad_q <= wr_addr;
            mi_q <= wr_misc;
         end else if (hit && wr_kind == WR_OVER) begin
            st_q[ST_OVER] <= 1'b1;
         end
      end
      assign st_arr[g] = st_q;
      assign ad_arr[g] = ad_q;
      assign mi_arr[g] = mi_q;
   end

   always_comb begin
      a_status = '0;
      b_status = '0;
      b_addr   = '0;
      b_misc   = '0;
      for (int i = 0; i < NBANK; i++) begin
         if (a_sel == CAP_CNT_W'(i)) a_status = st_arr[i];
         if (b_sel == CAP_CNT_W'(i)) begin
            b_status = st_arr[i];
            b_addr   = ad_arr[i];
            b_misc   = mi_arr[i];
         end
      end
   end
endmodule

// File: rtl/mcb_recorder.sv
module mcb_recorder
   import mcb_pkg::*;
#(
   parameter int NBANK = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [63:0]            cap_i,
   input  logic [63:0]            gctl_i,
   input  logic [NBANK*64-1:0]    bank_ctl_i,
   input  logic                   mce_en_i,
   input  logic                   inj_valid_i,
   input  logic [7:0]             inj_bank_i,
   input  logic [63:0]            inj_status_i,
   input  logic [63:0]            inj_gstat_i,
   input  logic [63:0]            inj_addr_i,
   input  logic [63:0]            inj_misc_i,
   input  logic                   inj_uncond_i,
   input  logic [7:0]             rd_bank_i,
   output logic                   res_valid_o,
   output logic [2:0]             res_action_o,
   output logic                   mce_irq_o,
   output logic                   reset_req_o,
   output logic [63:0]            gstat_o,
   output logic [63:0]            rd_status_o,
   output logic [63:0]            rd_addr_o,
   output logic [63:0]            rd_misc_o
);
   if (NBANK < 1 || NBANK > 255) begin : g_bad_nbank
      $error("mcb_recorder: NBANK must lie in 1..255");
   end
   if (REG_W != 64) begin : g_bad_width
      $error("mcb_recorder: register width must be 64");
   end

   logic [REG_W-1:0] ctl_sel, old_status, new_status, gstat_q;
   mcb_act_e         act_c;
   mcb_wr_e          wr_c, wr_g;
   logic             gstat_wr_c, irq_c, rst_c;

   always_comb begin
      ctl_sel = '0;
      for (int i = 0; i < NBANK; i++) begin
         if (inj_bank_i == CAP_CNT_W'(i)) ctl_sel = bank_ctl_i[i*REG_W +: REG_W];
      end
   end

   mcb_decide #(.NBANK(NBANK)) u_decide (
      .cap        (cap_i),
      .gctl       (gctl_i),
      .bank_ctl   (ctl_sel),
      .mce_en     (mce_en_i),
      .bank       (inj_bank_i),
      .status     (inj_status_i),
      .gstat_cur  (gstat_q),
      .uncond     (inj_uncond_i),
      .old_status (old_status),
      .act        (act_c),
      .wr         (wr_c),
      .new_status (new_status),
      .gstat_wr   (gstat_wr_c),
      .irq        (irq_c),
      .rst_req    (rst_c)
   );

   assign wr_g = inj_valid_i ? wr_c : WR_NONE;

   mcb_bank_store #(.NBANK(NBANK)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_sel    (inj_bank_i),
      .wr_kind   (wr_g),
      .wr_status (new_status),
      .wr_addr   (inj_addr_i),
      .wr_misc   (inj_misc_i),
      .a_sel     (inj_bank_i),
      .a_status  (old_status),
      .b_sel     (rd_bank_i),
      .b_status  (rd_status_o),
      .b_addr    (rd_addr_o),
      .b_misc    (rd_misc_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gstat_q      <= '0;
         res_valid_o  <= 1'b0;
         res_action_o <= 3'd0;
         mce_irq_o    <= 1'b0;
         reset_req_o  <= 1'b0;
      end else begin
         res_valid_o  <= inj_valid_i;
         res_action_o <= inj_valid_i ? 3'(act_c) : 3'd0;
         mce_irq_o    <= inj_valid_i & irq_c;
         reset_req_o  <= inj_valid_i & rst_c;
         if (inj_valid_i && gstat_wr_c) gstat_q <= inj_gstat_i;
      end
   end

   assign gstat_o = gstat_q;
endmodule

module mcb_recorder_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        inj_valid_i,
   input logic [63:0] inj_gstat_i,
   input logic        res_valid_o,
   input logic [2:0]  res_action_o,
   input logic        mce_irq_o,
   input logic        reset_req_o,
   input logic [63:0] gstat_o
);
   p_strobe_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |-> $past(inj_valid_i));
   p_quiet_without_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid_o |-> (!mce_irq_o && !reset_req_o));
   p_irq_means_inject_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mce_irq_o |-> (res_action_o == 3'd1 && !reset_req_o));
   p_irq_loads_gstat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mce_irq_o |-> (gstat_o == $past(inj_gstat_i)));
   p_reset_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req_o |-> (res_action_o == 3'd2 && $stable(gstat_o)));
   p_reject_keeps_gstat_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && res_action_o == 3'd3) |-> $stable(gstat_o));
   p_ignore_keeps_gstat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && res_action_o == 3'd0) |-> $stable(gstat_o));
   p_drop_keeps_gstat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && res_action_o == 3'd4) |-> $stable(gstat_o));
endmodule

bind mcb_recorder mcb_recorder_chk u_chk (.*);

// File: tb/mcb_recorder_tb.sv
module mcb_recorder_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 4;
   localparam logic [63:0] SV = 64'h1 << 63;
   localparam logic [63:0] SO = 64'h1 << 62;
   localparam logic [63:0] SU = 64'h1 << 61;
   localparam logic [63:0] SA = 64'h1 << 55;
   localparam logic [63:0] ONES = '1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [63:0] cap_i = 64'h104, gctl_i = ONES;
   logic [NB*64-1:0] bank_ctl_i = '1;
   logic mce_en_i = 1'b1;
   logic inj_valid_i = 1'b0, inj_uncond_i = 1'b0;
   logic [7:0] inj_bank_i = '0, rd_bank_i = '0;
   logic [63:0] inj_status_i = '0, inj_gstat_i = '0, inj_addr_i = '0, inj_misc_i = '0;
   logic res_valid_o, mce_irq_o, reset_req_o;
   logic [2:0] res_action_o;
   logic [63:0] gstat_o, rd_status_o, rd_addr_o, rd_misc_o;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mcb_recorder #(.NBANK(NB)) u_dut (.*);

   // reference model state
   logic [63:0] m_st [NB], m_ad [NB], m_mi [NB];
   string m_tag [NB];
   logic [63:0] m_gs;
   string g_tag = "R9";
   bit e_vld, e_irq, e_rst;
   int e_act;
   string e_tag = "R9";

   task automatic model_step();
      int b;
      logic [63:0] s, old;
      bit uc, inprog;
      b = int'(inj_bank_i);
      s = inj_status_i;
      inprog = m_gs[2];
      if (cap_i == 0 || b >= int'(cap_i[7:0]) || b >= NB || !s[63]) begin
         e_act = 3; e_tag = "R1"; return;
      end
      if (inprog && !s[55] && !inj_uncond_i) begin
         e_act = 0; e_tag = "R2"; return;
      end
      old = m_st[b];
      uc = s[61];
      if (uc) begin
         if (bank_ctl_i[b*64 +: 64] != ONES || (cap_i[8] && gctl_i != ONES)) begin
            e_act = 4; e_tag = "R3"; return;
         end
         if (inprog || !mce_en_i) begin
            e_act = 2; e_tag = "R4"; e_rst = 1; return;
         end
         if (old[63]) s = s | SO;
         m_st[b] = s; m_ad[b] = inj_addr_i; m_mi[b] = inj_misc_i; m_tag[b] = "R5";
         m_gs = inj_gstat_i; g_tag = "R5";
         e_act = 1; e_tag = "R5"; e_irq = 1;
      end else if (old[63] && old[61]) begin
         m_st[b] = old | SO; m_tag[b] = "R7";
         e_act = 1; e_tag = "R7";
      end else begin
         if (old[63]) s = s | SO;
         m_st[b] = s; m_ad[b] = inj_addr_i; m_mi[b] = inj_misc_i; m_tag[b] = "R6";
         e_act = 1; e_tag = "R6";
      end
   endtask

   always @(posedge clk) begin
      e_irq = 0; e_rst = 0;
      if (!rst_n) begin
         for (int i = 0; i < NB; i++) begin
            m_st[i] = 0; m_ad[i] = 0; m_mi[i] = 0; m_tag[i] = "R9";
         end
         m_gs = 0; g_tag = "R9"; e_vld = 0; e_act = 0; e_tag = "R9";
      end else begin
         e_vld = inj_valid_i;
         if (inj_valid_i) model_step();
      end
   end

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      #(CLK_PERIOD/4);
      if (!done) begin
         int r;
         r = int'(rd_bank_i);
         chk("R8", "strobe", 64'(res_valid_o), 64'(e_vld));
         if (e_vld) chk(e_tag, "action", 64'(res_action_o), 64'(e_act));
         chk("R5", "irq", 64'(mce_irq_o), 64'(e_irq));
         chk("R4", "reset_req", 64'(reset_req_o), 64'(e_rst));
         chk(g_tag, "gstat", gstat_o, m_gs);
         if (r < NB) begin
            chk(m_tag[r], "bank status", rd_status_o, m_st[r]);
            chk(m_tag[r], "bank addr", rd_addr_o, m_ad[r]);
            chk(m_tag[r], "bank misc", rd_misc_o, m_mi[r]);
         end
      end
   end

   always @(negedge clk) rd_bank_i <= (rd_bank_i == 8'(NB - 1)) ? 8'd0 : rd_bank_i + 8'd1;

   task automatic inj(int b, logic [63:0] s, logic [63:0] gs, bit unc = 0);
      @(negedge clk);
      inj_valid_i = 1; inj_bank_i = 8'(b); inj_status_i = s; inj_gstat_i = gs;
      inj_addr_i = {32'hA0D0_0000, 24'h0, 8'(b)} ^ s; inj_misc_i = ~s; inj_uncond_i = unc;
      @(negedge clk);
      inj_valid_i = 0; inj_uncond_i = 0;
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      repeat (4) @(negedge clk);
      // R9: outputs and banks checked at zero by the per-cycle comparison above
      // R1 rejects
      cap_i = 0; inj(0, SV | 64'h1, 0);
      cap_i = 64'h104; inj(4, SV | 64'h2, 0);
      inj(0, 64'h3, 0);
      cap_i = 64'h102; inj(2, SV | 64'h4, 0);
      cap_i = 64'h104;
      // R6 corrected into empty then onto corrected
      inj(0, SV | 64'h11, 0);
      inj(0, SV | 64'h12, 0);
      // R4 reset when enable low
      mce_en_i = 0; inj(1, SV | SU | 64'h21, 1); mce_en_i = 1;
      // R3 drops
      bank_ctl_i[1*64 +: 64] = 64'hFFFF_FFFF_FFFF_FFFE; inj(1, SV | SU | 64'h22, 1);
      bank_ctl_i = '1;
      gctl_i = 0; inj(1, SV | SU | 64'h23, 1);
      cap_i = 64'h004; inj(1, SV | SU | 64'h24, 64'h1);
      cap_i = 64'h104; gctl_i = ONES;
      // R5 uncorrected onto valid corrected: overflow
      inj(0, SV | SU | 64'h25, 64'h1);
      // R7 corrected onto uncorrected
      inj(1, SV | 64'h26, 0);
      // R5 with in-progress global status
      inj(3, SV | SU | 64'h27, 64'h5);
      // R2 ignore, bypass, action-required
      inj(2, SV | 64'h28, 0);
      inj(2, SV | SU | 64'h29, 0);
      inj(2, SV | 64'h2A, 0, 1);
      inj(2, SV | SU | SA | 64'h2B, 0);
      inj(2, SV | SU | 64'h2C, 0, 1);
      do_reset();
      // mixed stimulus
      for (int k = 0; k < 600; k++) begin
         logic [63:0] s, gs;
         int b;
         b = int'($urandom % 6);
         s = {$urandom, $urandom};
         s[63] = ($urandom % 8) != 0;
         s[61] = $urandom % 2;
         s[55] = ($urandom % 4) == 0;
         s[62] = ($urandom % 4) == 0;
         gs = 64'($urandom % 8);
         mce_en_i = ($urandom % 6) != 0;
         gctl_i = (($urandom % 8) == 0) ? 64'h0F : ONES;
         cap_i = (($urandom % 10) == 0) ? 64'h0 : {55'h0, 1'($urandom % 2), 8'(2 + $urandom % 3)};
         bank_ctl_i = '1;
         if (($urandom % 8) == 0) bank_ctl_i[($urandom % NB)*64] = 1'b0;
         inj(b, s, gs, ($urandom % 5) == 0);
         if (k % 150 == 149) do_reset();
      end
      repeat (3) @(negedge clk);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule